// File: doc/BRIEF.md
# SPI host register-command engine

This block sits on the host side of a byte-wide, full-duplex SPI link to a peripheral chip and carries out one register-style command transaction at a time. A caller presents an opcode, an address, optional 32-bit write data, a transfer size (used only by the block-command headers), a clockless-register flag and a CRC-enable flag, then pulses a start strobe. The engine emits the command frame byte by byte over a request/acknowledge byte link. When CRC is enabled it appends a CRC7 byte. It then sends zero padding bytes for as long as the response window of that command class lasts.

While the padding goes out, the engine parses the bytes that come back. It skips a leading byte for the control commands (reset, terminate, repeat). It compares the echoed opcode and the status byte. For reads it scans for a data header, which is a byte whose upper nibble is all ones. Short reads then take four data bytes and, with CRC on, two CRC bytes. The whole window is always clocked through. The engine then raises a one-cycle done pulse with a 2-bit result and, for short reads, the assembled 32-bit word.

Top module: `spireg_cmd_host`

## Requirements
- R1: After reset `cmd_busy`, `cmd_done` and `lnk_req` are 0 and `cmd_result` is 0. A start is taken only in idle. A start seen while `cmd_busy` is high, including the done cycle, has no effect on the frame in flight and does not begin a new command.
- R2: The first frame byte is the opcode. Opcode 0xCA (single read) is followed by a 24-bit address. Opcode 0xC9 (single write) is followed by a 24-bit address and then the 32-bit data. Opcodes 0xC1/0xC2 are followed by a 24-bit address and a 16-bit size. Opcodes 0xC7/0xC8 are followed by a 24-bit address and a 24-bit size. Every multi-byte field is sent most significant byte first.
- R3: Opcodes 0xC4 (internal read) and 0xC3 (internal write) send a 16-bit address, high byte first, and OR `cmd_clkless` into bit 7 of that high byte. 0xC4 then sends one 0x00 byte, and 0xC3 sends the 32-bit data MSB first. `cmd_clkless` does not change the frame of any other opcode.
- R4: Reset (0xCF) sends three 0xFF argument bytes. Terminate (0xC5) and repeat (0xC6) send three 0x00 bytes.
- R5: With `cmd_crc_en`=1 the byte after the arguments is the CRC7 of all earlier frame bytes. The CRC uses polynomial x^7+x^3+1, seed 0x7F, bits MSB first, and is placed in bits 7:1 with bit 0 zero. With `cmd_crc_en`=0 that byte is not sent.
- R6: After the frame the engine sends 0x00 padding bytes. There are 6 for 0xCF/0xC5/0xC6, 10 for 0xC4/0xCA (12 with CRC), and 5 for all other opcodes. Bytes received during the frame are ignored.
- R7: For 0xCF/0xC5/0xC6 the first received padding byte is skipped. The next byte must equal the opcode, or the result is fail (1).
- R8: The byte after the echoed opcode must be 0x00, or the result is fail (1). A command with no read phase that passes both checks ends with result ok (0).
- R9: For 0xC4/0xCA the bytes after the status are scanned for one whose bits 7:4 are 0xF. The next 4 bytes form `cmd_rdata`, with the first byte in bits 7:0. With CRC on, 2 more bytes are consumed unchecked. The result is ok (0).
- R10: If a read (0xC4, 0xCA, 0xC2, 0xC8) finds no header within the window, the result is reset-error (2).
- R11: If a short read's header comes so late that its 4 data bytes, or its 2 CRC bytes when CRC is on, do not fit inside the window, the result is fail (1).
- R12: For the block reads 0xC2/0xC8 a header inside the window gives result ok (0) and no data word is taken.
- R13: Any other opcode gives `cmd_done`=1 and result fail (1) in the cycle after the start, with no link request.
- R14: `lnk_txd` is held while `lnk_req` is high and `lnk_ack` is low, and each `lnk_ack` moves to the next byte. `cmd_done` pulses for exactly one cycle, in the cycle after the last acknowledge. `cmd_result` and `cmd_rdata` stay valid until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe, taken in idle only |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Register or memory address |
| cmd_wdata | input | 32 | Write data for single and internal writes |
| cmd_size | input | 24 | Size field for block-command headers |
| cmd_clkless | input | 1 | Marks an internal access to a clockless register |
| cmd_crc_en | input | 1 | Append CRC7 byte and expect read CRC bytes |
| cmd_busy | output | 1 | Command in progress, including done cycle |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_result | output | 2 | 0 ok, 1 fail, 2 reset-error |
| cmd_rdata | output | 32 | Read word, first received byte in bits 7:0 |
| lnk_req | output | 1 | Byte exchange requested |
| lnk_txd | output | 8 | Byte to send |
| lnk_ack | input | 1 | Byte exchange complete this cycle |
| lnk_rxd | input | 8 | Byte received in the exchange being acknowledged |

## Verification
A caller's start strobe can land in the same cycle as the engine finishing a transfer, or in its done cycle. The bench therefore pulses start with a different opcode in the middle of a frame and again in the done cycle. The cycle-by-cycle model then checks that the expected frame continues unchanged and that the engine returns to idle without starting a second command. In a second coincidence, the data header and the end of the response window fall together. Headers are placed at the last position that still fits, and one byte later. The model judges the first placement as ok and the second as fail, and a window with no header as reset-error. The acknowledge is stalled pseudo-randomly throughout, so byte advance and byte hold are both exercised in every command.

// File: rtl/srce_pkg.sv
package srce_pkg;
   localparam int ADDR_W     = 24;
   localparam int WORD_W     = 32;
   localparam int SIZE_W     = 24;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int HDR_MAX    = 8;

   localparam logic [7:0] OP_DMA_WR  = 8'hC1;
   localparam logic [7:0] OP_DMA_RD  = 8'hC2;
   localparam logic [7:0] OP_INT_WR  = 8'hC3;
   localparam logic [7:0] OP_INT_RD  = 8'hC4;
   localparam logic [7:0] OP_TERM    = 8'hC5;
   localparam logic [7:0] OP_RPT     = 8'hC6;
   localparam logic [7:0] OP_XDMA_WR = 8'hC7;
   localparam logic [7:0] OP_XDMA_RD = 8'hC8;
   localparam logic [7:0] OP_SGL_WR  = 8'hC9;
   localparam logic [7:0] OP_SGL_RD  = 8'hCA;
   localparam logic [7:0] OP_RST     = 8'hCF;

   typedef enum logic [2:0] {CL_BAD, CL_CTRL, CL_SHORT, CL_BLOCK, CL_WRITE} op_cls_e;
   typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_RESET = 2'd2} res_e;

   function automatic op_cls_e op_class(input logic [7:0] op);
      case (op)
         OP_RST, OP_TERM, OP_RPT:                  return CL_CTRL;
         OP_INT_RD, OP_SGL_RD:                     return CL_SHORT;
         OP_DMA_RD, OP_XDMA_RD:                    return CL_BLOCK;
         OP_DMA_WR, OP_XDMA_WR, OP_INT_WR, OP_SGL_WR: return CL_WRITE;
         default:                                  return CL_BAD;
      endcase
   endfunction
endpackage

// File: rtl/srce_crc7.sv
module srce_crc7 #(
   parameter logic [6:0] SEED = 7'h7F,
   parameter logic [6:0] POLY = 7'h09
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       upd,
   input  logic [7:0] din,
   output logic [6:0] crc
);
   logic [6:0] crc_r;
   logic [6:0] chain [0:8];

   assign chain[0] = crc_r;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb = chain[b][6] ^ din[7-b];
      assign chain[b+1] = {chain[b][5:0], 1'b0} ^ (fb ? POLY : 7'h00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_r <= SEED;
      else if (clear)  crc_r <= SEED;
      else if (upd)    crc_r <= chain[8];
   end

   assign crc = crc_r;
endmodule

// File: rtl/srce_frame_gen.sv
module srce_frame_gen
   import srce_pkg::*;
#(
   parameter int DUMMY_N = 3,
   parameter int CNT_W   = 5
) (
   input  logic [7:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [SIZE_W-1:0] size,
   input  logic              clkless,
   input  logic              crc_en,
   input  logic [CNT_W-1:0]  idx,
   input  logic [6:0]        crc,
   output logic [CNT_W-1:0]  base_len,
   output logic [CNT_W-1:0]  frame_len,
   output logic [CNT_W-1:0]  total_len,
   output logic [7:0]        txd
);
   localparam int PAD_CTRL  = 1 + 2 + DUMMY_N;
   localparam int PAD_SHORT = 2 + 1 + WORD_BYTES + DUMMY_N;
   localparam int PAD_OTHER = 2 + DUMMY_N;

   logic [7:0]       hb [HDR_MAX];
   logic [CNT_W-1:0] pad_len;
   op_cls_e          cls;

   assign cls = op_class(op);

   always_comb begin
      for (int k = 0; k < HDR_MAX; k++) hb[k] = 8'h00;
      hb[0]    = op;
      base_len = CNT_W'(4);
      case (op)
         OP_SGL_RD: begin
            {hb[1], hb[2], hb[3]} = addr;
         end
         OP_SGL_WR: begin
            {hb[1], hb[2], hb[3]} = addr;
            {hb[4], hb[5], hb[6], hb[7]} = wdata;
            base_len = CNT_W'(8);
         end
         OP_INT_RD: begin
            hb[1] = {addr[15] | clkless, addr[14:8]};
            hb[2] = addr[7:0];
         end
         OP_INT_WR: begin
            hb[1] = {addr[15] | clkless, addr[14:8]};
            hb[2] = addr[7:0];
            {hb[3], hb[4], hb[5], hb[6]} = wdata;
            base_len = CNT_W'(7);
         end
         OP_DMA_WR, OP_DMA_RD: begin
            {hb[1], hb[2], hb[3]} = addr;
            {hb[4], hb[5]} = size[15:0];
            base_len = CNT_W'(6);
         end
         OP_XDMA_WR, OP_XDMA_RD: begin
            {hb[1], hb[2], hb[3]} = addr;
            {hb[4], hb[5], hb[6]} = size;
            base_len = CNT_W'(7);
         end
         OP_RST: begin
            hb[1] = 8'hFF; hb[2] = 8'hFF; hb[3] = 8'hFF;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (cls)
         CL_CTRL:  pad_len = CNT_W'(PAD_CTRL);
         CL_SHORT: pad_len = CNT_W'(PAD_SHORT) + (crc_en ? CNT_W'(2) : CNT_W'(0));
         default:  pad_len = CNT_W'(PAD_OTHER);
      endcase
   end

   assign frame_len = base_len + CNT_W'(crc_en);
   assign total_len = frame_len + pad_len;

   always_comb begin
      if (idx < base_len)                txd = hb[idx[2:0]];
      else if (crc_en && idx == base_len) txd = {crc, 1'b0};
      else                               txd = 8'h00;
   end
endmodule

// File: rtl/srce_rsp_parse.sv
module srce_rsp_parse
   import srce_pkg::*;
#(
   parameter logic [3:0] HDR_MARK = 4'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [7:0]        new_op,
   input  logic              new_crc,
   input  logic              stb,
   input  logic [7:0]        rxd,
   output logic [1:0]        verdict,
   output logic [WORD_W-1:0] rdata
);
   localparam int CW = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;

   typedef enum logic [2:0] {P_SKIP, P_ECHO, P_STAT, P_HUNT, P_DATA, P_TAIL, P_END} ph_e;

   ph_e           ph;
   op_cls_e       cls_r;
   logic [7:0]    op_r;
   logic          crc_r;
   logic [CW-1:0] cnt;
   logic          fail_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= P_END; cls_r <= CL_BAD; op_r <= 8'h00; crc_r <= 1'b0;
         cnt <= '0; fail_r <= 1'b0; rdata <= '0;
      end else if (restart) begin
         cls_r  <= op_class(new_op);
         op_r   <= new_op;
         crc_r  <= new_crc;
         ph     <= (op_class(new_op) == CL_CTRL) ? P_SKIP : P_ECHO;
         cnt    <= '0;
         fail_r <= 1'b0;
         rdata  <= '0;
      end else if (stb) begin
         case (ph)
            P_SKIP: ph <= P_ECHO;
            P_ECHO: begin
               if (rxd != op_r) begin fail_r <= 1'b1; ph <= P_END; end
               else ph <= P_STAT;
            end
            P_STAT: begin
               if (rxd != 8'h00) begin fail_r <= 1'b1; ph <= P_END; end
               else if (cls_r == CL_SHORT || cls_r == CL_BLOCK) ph <= P_HUNT;
               else ph <= P_END;
            end
            P_HUNT: begin
               if (rxd[7:4] == HDR_MARK) begin
                  ph  <= (cls_r == CL_SHORT) ? P_DATA : P_END;
                  cnt <= '0;
               end
            end
            P_DATA: begin
               rdata[cnt*8 +: 8] <= rxd;
               if (cnt == CW'(WORD_BYTES - 1)) begin
                  cnt <= '0;
                  ph  <= crc_r ? P_TAIL : P_END;
               end else cnt <= cnt + 1'b1;
            end
            P_TAIL: begin
               if (cnt == CW'(1)) ph <= P_END;
               else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (fail_r)                          verdict = RES_FAIL;
      else if (ph == P_HUNT)               verdict = RES_RESET;
      else if (ph == P_DATA || ph == P_TAIL) verdict = RES_FAIL;
      else                                 verdict = RES_OK;
   end

   assert_hunt_to_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stb && !restart && ph == P_HUNT && rxd[7:4] == HDR_MARK && cls_r == CL_SHORT |=> ph == P_DATA);
   assert_echo_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stb && !restart && ph == P_ECHO && rxd != op_r |=> verdict == RES_FAIL);
endmodule

// File: rtl/spireg_cmd_host.sv
module spireg_cmd_host
   import srce_pkg::*;
#(
   parameter int         DUMMY_N  = 3,
   parameter logic [6:0] CRC_SEED = 7'h7F,
   parameter logic [3:0] HDR_MARK = 4'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [7:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] cmd_wdata,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic              cmd_clkless,
   input  logic              cmd_crc_en,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic [1:0]        cmd_result,
   output logic [WORD_W-1:0] cmd_rdata,
   output logic              lnk_req,
   output logic [7:0]        lnk_txd,
   input  logic              lnk_ack,
   input  logic [7:0]        lnk_rxd
);
   localparam int MAX_TOTAL = HDR_MAX + 1 + 2 + 1 + WORD_BYTES + DUMMY_N + 2 + 1;
   localparam int CNT_W     = $clog2(MAX_TOTAL + 1);

   if (DUMMY_N < 1 || DUMMY_N > 16) begin : g_bad_dummy
      $error("DUMMY_N must lie in 1..16");
   end
   if (HDR_MARK == 4'h0) begin : g_bad_mark
      $error("HDR_MARK must be nonzero");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("protocol word must be 32 bits");
   end

   typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} st_e;

   st_e               st;
   logic [CNT_W-1:0]  idx;
   logic [7:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic [SIZE_W-1:0] size_q;
   logic              clk_q, crc_q, bad_q;
   logic [CNT_W-1:0]  base_len, frame_len, total_len;
   logic [6:0]        crc_val;
   logic [1:0]        verdict;
   logic              accept, xfer_ack;

   assign accept   = cmd_start && st == S_IDLE;
   assign xfer_ack = st == S_XFER && lnk_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; idx <= '0; op_q <= 8'h00; addr_q <= '0; wdata_q <= '0;
         size_q <= '0; clk_q <= 1'b0; crc_q <= 1'b0; bad_q <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (accept) begin
               op_q    <= cmd_op;
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               size_q  <= cmd_size;
               clk_q   <= cmd_clkless;
               crc_q   <= cmd_crc_en;
               idx     <= '0;
               bad_q   <= op_class(cmd_op) == CL_BAD;
               st      <= (op_class(cmd_op) == CL_BAD) ? S_FIN : S_XFER;
            end
            S_XFER: if (lnk_ack) begin
               if (idx == total_len - CNT_W'(1)) st <= S_FIN;
               else idx <= idx + CNT_W'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   srce_frame_gen #(.DUMMY_N(DUMMY_N), .CNT_W(CNT_W)) u_frame (
      .op(op_q), .addr(addr_q), .wdata(wdata_q), .size(size_q),
      .clkless(clk_q), .crc_en(crc_q), .idx(idx), .crc(crc_val),
      .base_len(base_len), .frame_len(frame_len), .total_len(total_len),
      .txd(lnk_txd)
   );

   srce_crc7 #(.SEED(CRC_SEED)) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .upd(xfer_ack && idx < base_len), .din(lnk_txd), .crc(crc_val)
   );

   srce_rsp_parse #(.HDR_MARK(HDR_MARK)) u_parse (
      .clk(clk), .rst_n(rst_n), .restart(accept), .new_op(cmd_op),
      .new_crc(cmd_crc_en), .stb(xfer_ack && idx >= frame_len),
      .rxd(lnk_rxd), .verdict(verdict), .rdata(cmd_rdata)
   );

   assign cmd_busy   = st != S_IDLE;
   assign cmd_done   = st == S_FIN;
   assign lnk_req    = st == S_XFER;
   assign cmd_result = bad_q ? RES_FAIL : verdict;

   assert_busy_ignores_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_busy && cmd_start |=> $stable(op_q));
   assert_first_is_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req && idx == '0 |-> lnk_txd == op_q);
   assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req && idx >= frame_len |-> lnk_txd == 8'h00);
   assert_reset_only_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done && cmd_result == RES_RESET |->
         (op_class(op_q) == CL_SHORT || op_class(op_q) == CL_BLOCK));
   assert_bad_no_link_R13: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |-> !lnk_req);
   assert_hold_byte_R14: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req && !lnk_ack |=> lnk_req && $stable(lnk_txd));
   assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);
endmodule

// File: tb/test_spireg_cmd_host.sv
`timescale 1ns/1ps
module test_spireg_cmd_host;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [7:0]  cmd_op = 8'h00;
   logic [23:0] cmd_addr = '0;
   logic [31:0] cmd_wdata = '0;
   logic [23:0] cmd_size = '0;
   logic        cmd_clkless = 1'b0;
   logic        cmd_crc_en = 1'b0;
   logic        cmd_busy, cmd_done, lnk_req, lnk_ack = 1'b0;
   logic [1:0]  cmd_result;
   logic [31:0] cmd_rdata;
   logic [7:0]  lnk_txd, lnk_rxd = 8'h00;

   int total = 0, bad = 0, cyc = 0;
   logic [31:0] seed = 32'h1234_5678;
   logic [7:0]  txq[$];
   logic [7:0]  rxq[$];
   logic [6:0]  crcv;

   always #2 clk = ~clk;

   spireg_cmd_host i_spireg_cmd_host (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
      .cmd_clkless(cmd_clkless), .cmd_crc_en(cmd_crc_en), .cmd_busy(cmd_busy),
      .cmd_done(cmd_done), .cmd_result(cmd_result), .cmd_rdata(cmd_rdata),
      .lnk_req(lnk_req), .lnk_txd(lnk_txd), .lnk_ack(lnk_ack), .lnk_rxd(lnk_rxd)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         total++; bad++;
         $display("FAIL R14 watchdog actual=%0d expected=0", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [6:0] crc_step(input logic [6:0] c, input logic [7:0] b);
      logic [7:0] x;
      x = {c, 1'b0} ^ b;
      for (int k = 0; k < 8; k++) x = {x[6:0], 1'b0} ^ (x[7] ? 8'h12 : 8'h00);
      return x[7:1];
   endfunction

   task automatic put(input logic [7:0] b);
      txq.push_back(b);
      crcv = crc_step(crcv, b);
   endtask

   function automatic int kind(input logic [7:0] op); // 0 bad 1 ctrl 2 short 3 block 4 write
      case (op)
         8'hCF, 8'hC5, 8'hC6: return 1;
         8'hC4, 8'hCA:        return 2;
         8'hC2, 8'hC8:        return 3;
         8'hC1, 8'hC3, 8'hC7, 8'hC9: return 4;
         default:             return 0;
      endcase
   endfunction

   task automatic run(input logic [7:0] op, input logic [23:0] a, input logic [31:0] wd,
                      input logic [23:0] sz, input bit ck, input bit crc,
                      input logic [7:0] echo, input logic [7:0] stat, input int hdr,
                      input logic [31:0] dat, input logic [1:0] xres, input bit poke,
                      input string tag);
      int k, plen, p, i, flen;
      logic [7:0] pb [0:31];
      bit ack, poked;
      k = kind(op);
      txq.delete(); rxq.delete(); crcv = 7'h7F;
      if (k != 0) begin
         put(op);
         case (op)
            8'hCA: begin put(a[23:16]); put(a[15:8]); put(a[7:0]); end
            8'hC9: begin put(a[23:16]); put(a[15:8]); put(a[7:0]);
                         put(wd[31:24]); put(wd[23:16]); put(wd[15:8]); put(wd[7:0]); end
            8'hC4: begin put({a[15] | ck, a[14:8]}); put(a[7:0]); put(8'h00); end
            8'hC3: begin put({a[15] | ck, a[14:8]}); put(a[7:0]);
                         put(wd[31:24]); put(wd[23:16]); put(wd[15:8]); put(wd[7:0]); end
            8'hC1, 8'hC2: begin put(a[23:16]); put(a[15:8]); put(a[7:0]);
                         put(sz[15:8]); put(sz[7:0]); end
            8'hC7, 8'hC8: begin put(a[23:16]); put(a[15:8]); put(a[7:0]);
                         put(sz[23:16]); put(sz[15:8]); put(sz[7:0]); end
            8'hCF: begin put(8'hFF); put(8'hFF); put(8'hFF); end
            default: begin put(8'h00); put(8'h00); put(8'h00); end
         endcase
         if (crc) txq.push_back({crcv, 1'b0});
         flen = txq.size();
         plen = (k == 1) ? 6 : (k == 2) ? (crc ? 12 : 10) : 5;
         for (int j = 0; j < 32; j++) pb[j] = 8'h3C;
         p = 0;
         if (k == 1) begin pb[0] = 8'hF7; p = 1; end
         pb[p] = echo; pb[p+1] = stat;
         if (hdr >= 0) begin
            pb[hdr] = 8'hF5;
            for (int j = 0; j < 4; j++) pb[hdr+1+j] = dat[8*j +: 8];
            if (crc && k == 2) begin pb[hdr+5] = 8'h5A; pb[hdr+6] = 8'h5A; end
         end
         for (int j = 0; j < flen; j++) rxq.push_back(8'hFF);
         for (int j = 0; j < plen; j++) begin txq.push_back(8'h00); rxq.push_back(pb[j]); end
      end
      @(negedge clk);
      cmd_start = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_size = sz;
      cmd_clkless = ck; cmd_crc_en = crc;
      @(negedge clk);
      cmd_start = 1'b0;
      if (k == 0) begin
         chk(cmd_done == 1'b1 && lnk_req == 1'b0, {"R13 done without link ", tag}, {cmd_done, lnk_req}, 2);
         chk(cmd_result == 2'd1, {"R13 result ", tag}, cmd_result, 1);
         @(negedge clk);
         chk(cmd_busy == 1'b0 && cmd_done == 1'b0, {"R14 back to idle ", tag}, cmd_busy, 0);
         return;
      end
      i = 0; poked = 1'b0;
      while (i < txq.size()) begin
         chk(cmd_busy && lnk_req && !cmd_done, {"R14 req/busy ", tag}, {cmd_busy, lnk_req, cmd_done}, 6);
         chk(lnk_txd == txq[i], $sformatf("R2 R5 R6 byte %0d %s", i, tag), lnk_txd, txq[i]);
         if (poke && i == 2 && !poked) begin
            cmd_start = 1'b1; cmd_op = 8'hCA; cmd_addr = 24'hFFFFFF; poked = 1'b1;
         end
         seed = seed * 32'd1103515245 + 32'd12345;
         ack = seed[17:16] != 2'b00;
         lnk_ack = ack; lnk_rxd = rxq[i];
         @(negedge clk);
         cmd_start = 1'b0; lnk_ack = 1'b0;
         if (ack) i++;
      end
      chk(cmd_done && cmd_busy && !lnk_req, {"R14 done pulse ", tag}, {cmd_done, cmd_busy, lnk_req}, 6);
      chk(cmd_result == xres, {"R7 R8 R10 R11 R12 result ", tag}, cmd_result, xres);
      if (xres == 2'd0 && k == 2)
         chk(cmd_rdata == dat, {"R9 read word ", tag}, cmd_rdata, dat);
      if (poke) begin cmd_start = 1'b1; cmd_op = 8'hC9; end
      @(negedge clk);
      cmd_start = 1'b0;
      chk(!cmd_done && !cmd_busy, {"R1 R14 idle after done ", tag}, {cmd_done, cmd_busy}, 0);
      chk(cmd_result == xres, {"R14 result held ", tag}, cmd_result, xres);
      @(negedge clk);
      chk(!cmd_busy && !lnk_req, {"R1 start in done cycle ignored ", tag}, {cmd_busy, lnk_req}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!cmd_busy && !cmd_done && !lnk_req && cmd_result == 2'd0, "R1 reset state",
          {cmd_busy, cmd_done, lnk_req, cmd_result}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cmd_busy && !lnk_req, "R1 idle after reset", {cmd_busy, lnk_req}, 0);
      //   op    addr        wdata         size        ck crc echo   stat  hdr data          res poke
      run(8'hCA, 24'h123456, 32'h0,        24'h0,      1, 0, 8'hCA, 8'h00, 2, 32'h89ABCDEF, 2'd0, 0, "R2 R3 single read");
      run(8'hCA, 24'hA0B0C0, 32'h0,        24'h0,      0, 1, 8'hCA, 8'h00, 4, 32'h01020304, 2'd0, 0, "R5 R9 read crc");
      run(8'hC9, 24'h00F00D, 32'hDEADBEEF, 24'h0,      0, 1, 8'hC9, 8'h00, -1, 32'h0,       2'd0, 0, "R2 R5 single write");
      run(8'hC3, 24'h000024, 32'h11223344, 24'h0,      1, 0, 8'hC3, 8'h00, -1, 32'h0,       2'd0, 0, "R3 internal write");
      run(8'hC4, 24'h001234, 32'h0,        24'h0,      0, 1, 8'hC4, 8'h00, 5, 32'h55AA33CC, 2'd0, 0, "R3 R9 internal read late header");
      run(8'hCF, 24'h0,      32'h0,        24'h0,      0, 1, 8'hCF, 8'h00, -1, 32'h0,       2'd0, 0, "R4 R7 reset");
      run(8'hC5, 24'h0,      32'h0,        24'h0,      0, 0, 8'hC6, 8'h00, -1, 32'h0,       2'd1, 0, "R4 R7 terminate bad echo");
      run(8'hC6, 24'h0,      32'h0,        24'h0,      0, 0, 8'hC6, 8'h00, -1, 32'h0,       2'd0, 0, "R4 repeat");
      run(8'hC1, 24'h345678, 32'h0,        24'h00ABCD, 0, 1, 8'hC1, 8'h01, -1, 32'h0,       2'd1, 0, "R8 dma write bad status");
      run(8'hC8, 24'h222222, 32'h0,        24'h012345, 0, 0, 8'hC8, 8'h00, 4, 32'h0,        2'd0, 0, "R12 ext block read");
      run(8'hC2, 24'h333333, 32'h0,        24'h000100, 0, 1, 8'hC2, 8'h00, -1, 32'h0,       2'd2, 0, "R10 R12 block read no header");
      run(8'hCA, 24'h444444, 32'h0,        24'h0,      0, 1, 8'hCA, 8'h00, -1, 32'h0,       2'd2, 0, "R10 read no header");
      run(8'hCA, 24'h555555, 32'h0,        24'h0,      0, 0, 8'hCA, 8'h00, 6, 32'h0,        2'd1, 0, "R11 header too late");
      run(8'hC4, 24'h006666, 32'h0,        24'h0,      0, 1, 8'hC4, 8'h00, 6, 32'h0,        2'd1, 0, "R11 crc past window");
      run(8'hC0, 24'h0,      32'h0,        24'h0,      0, 0, 8'h00, 8'h00, -1, 32'h0,       2'd1, 0, "R13 unknown opcode");
      run(8'hC7, 24'h7A7B7C, 32'h0,        24'h0FEDCB, 1, 1, 8'hC7, 8'h00, -1, 32'h0,       2'd0, 1, "R1 R14 ext write with start pokes");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule